// File: doc/BRIEF.md
# Bit-Serial Convolutional Interleaver and Deinterleaver

This block spreads a serial bit stream across a fixed number of delay lines so that a burst of channel errors lands on bits that were far apart at the source. It then gathers the bits back into their original order. A single line selector picks one line for each accepted input bit and steps through the lines in turn. Transmit line `j` holds `j*STEP` stages, and receive line `j` holds `(LINES-1-j)*STEP` stages. As a result, every bit passes through the same total number of stages.

The top joins both halves. The interleaved channel stream is brought out on `ch_bit` and fed straight into the deinterleaver, so it can be observed, or a fault can be injected into it, in a larger system. Only the line under the selector shifts, and only when `in_valid` is high. Idle cycles therefore freeze the whole structure, and both halves stay aligned. With the defaults (`LINES=4`, `STEP=2`) the end-to-end delay is 24 accepted bits.

Top module: `conv_ilv_pair`

## Requirements
- R1: On accepted bit number `m` (counted from 0 after reset), the selected line is `j = m mod LINES`. `ch_bit` then equals input bit `m - j*STEP*LINES`, or 0 when that index is negative. Line 0 holds no stages and passes the input through in the same cycle.
- R2: Receive line `j` holds `(LINES-1-j)*STEP` stages. On the last line, `out_bit` equals `ch_bit` in the same cycle.
- R3: The line selector is 0 after reset and advances by one for each accepted bit. After line `LINES-1` it wraps back to line 0.
- R4: While `in_valid` is low, no line shifts and the selector holds its value. The value on `in_bit` in such a cycle is ignored.
- R5: On accepted bit `m`, `out_bit` equals input bit `m - LINES*(LINES-1)*STEP`. This is a delay of 24 accepted bits with the defaults.
- R6: All stages reset to 0. For the first `LINES*(LINES-1)*STEP` accepted bits after reset, `out_bit` is 0.
- R7: Two input bits that are adjacent, where the first is not on the last line, appear on the channel `STEP*LINES+1` positions apart.
- R8: `out_valid` follows `in_valid` in the same cycle, including while reset is held.
- R9: A reset applied in the middle of a run clears all lines and the selector. The output then behaves exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; lines shift on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept strobe for `in_bit` |
| in_bit | input | 1 | Serial source bit |
| ch_bit | output | 1 | Interleaved channel bit (combinational from selected transmit line) |
| out_valid | output | 1 | Strobe for `out_bit`, equal to `in_valid` |
| out_bit | output | 1 | Deinterleaved bit, source order restored |

## Verification
Both `ch_bit` and `out_bit` are combinational from the selected line. Each is therefore due in the same cycle as the accepted input bit that selects it. The stored contents that produce them date from earlier visits, which are counted in accepted bits rather than clock cycles. The bench drives each input on the falling edge and samples 1 ns later, before the rising edge that shifts the line. It compares the samples against the bit `j*STEP*LINES` back (channel) or `LINES*(LINES-1)*STEP` back (output) in its own history of accepted bits. Idle cycles do not advance that history, which is how the stall rule is confirmed.

// File: rtl/cilv_pkg.sv
package cilv_pkg;

    // Number of storage stages on line idx. The receive side mirrors the order.
    function automatic int line_depth(input int idx, input int lines,
                                      input int step, input bit mirror);
        if (mirror)
            return (lines - 1 - idx) * step;
        return idx * step;
    endfunction

    // Accepted bits between a source bit and its reappearance at the output.
    function automatic int path_latency(input int lines, input int step);
        return lines * (lines - 1) * step;
    endfunction

endpackage

// File: rtl/cilv_commutator.sv
module cilv_commutator #(
    parameter int LINES = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] sel
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } comm_state_t;

    comm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.idx == LAST)
                st_d.idx = '0;
            else
                st_d.idx = st_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign sel = st_q.idx;

endmodule

// File: rtl/cilv_delay_line.sv
module cilv_delay_line #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [DEPTH-1:0] sr;
    } dl_state_t;

    dl_state_t st_d, st_q;

    // Entry stage is bit 0; exit stage is bit DEPTH-1.
    always_comb begin
        st_d = st_q;
        if (shift_en)
            st_d.sr = (st_q.sr << 1) | DEPTH'(din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dout = st_q.sr[DEPTH-1];

endmodule

// File: rtl/cilv_line_bank.sv
module cilv_line_bank #(
    parameter int LINES  = 4,
    parameter int STEP   = 2,
    parameter bit MIRROR = 1'b0,
    parameter int IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] sel,
    input  logic             din,
    output logic             dout
);

    logic [LINES-1:0] tap;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam int DEPTH = cilv_pkg::line_depth(g, LINES, STEP, MIRROR);
        if (DEPTH == 0) begin : g_wire
            assign tap[g] = din;
        end else begin : g_reg
            logic hit;
            assign hit = adv && (sel == IDX_W'(g));
            cilv_delay_line #(.DEPTH(DEPTH)) u_dl (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (hit),
                .din      (din),
                .dout     (tap[g])
            );
        end
    end

    assign dout = tap[sel];

endmodule

// File: rtl/conv_ilv_pair.sv
module conv_ilv_pair #(
    parameter int LINES = 4,
    parameter int STEP  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic ch_bit,
    output logic out_valid,
    output logic out_bit
);

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    logic [IDX_W-1:0] line_sel;

    cilv_commutator #(.LINES(LINES), .IDX_W(IDX_W)) u_comm (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .sel   (line_sel)
    );

    cilv_line_bank #(.LINES(LINES), .STEP(STEP), .MIRROR(1'b0), .IDX_W(IDX_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .sel   (line_sel),
        .din   (in_bit),
        .dout  (ch_bit)
    );

    cilv_line_bank #(.LINES(LINES), .STEP(STEP), .MIRROR(1'b1), .IDX_W(IDX_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .sel   (line_sel),
        .din   (ch_bit),
        .dout  (out_bit)
    );

    assign out_valid = in_valid;

endmodule

// File: rtl/cilv_pair_chk.sv
module cilv_pair_chk #(
    parameter int LINES = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_bit,
    input logic             ch_bit,
    input logic             out_bit,
    input logic [IDX_W-1:0] sel
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    AST_SEL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel == LAST) |=> (sel == '0)); // R3

    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel != LAST) |=> (sel == $past(sel) + IDX_W'(1))); // R3

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sel)); // R4

    AST_TX_HEAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel == '0) |-> (ch_bit == in_bit)); // R1

    AST_RX_TAIL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel == LAST) |-> (out_bit == ch_bit)); // R2

endmodule

bind conv_ilv_pair cilv_pair_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .ch_bit   (ch_bit),
    .out_bit  (out_bit),
    .sel      (line_sel)
);

// File: tb/conv_ilv_pair_tb.sv
module conv_ilv_pair_tb;

    localparam int LINES = 4;
    localparam int STEP  = 2;
    localparam int LAT   = LINES * (LINES - 1) * STEP;
    localparam int HMAX  = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic ch_bit, out_valid, out_bit;

    int  n_checks = 0;
    int  n_err = 0;
    int  m = 0;
    bit  done = 1'b0;
    logic in_hist [HMAX];
    logic ch_hist [HMAX];

    always #2 clk = ~clk;

    conv_ilv_pair #(.LINES(LINES), .STEP(STEP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .ch_bit    (ch_bit),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    function automatic logic exp_ch(input int pos);
        int j   = pos % LINES;
        int src = pos - j * STEP * LINES;
        return (src >= 0) ? in_hist[src] : 1'b0;
    endfunction

    function automatic logic exp_out(input int pos);
        int src = pos - LAT;
        return (src >= 0) ? in_hist[src] : 1'b0;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0b expected %0b (accepted bit %0d)", tag, act, exp, m);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1 chk("R8", out_valid, 1'b0);
        rst_n = 1'b1;
        m = 0;
        for (int i = 0; i < HMAX; i++) begin
            in_hist[i] = 1'b0;
            ch_hist[i] = 1'b0;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_bit = 1'($urandom);
        #1 chk("R8", out_valid, 1'b0);
    endtask

    task automatic push(input logic b, input string early_tag, input string late_tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_bit = b;
        in_hist[m] = b;
        #1;
        ch_hist[m] = ch_bit;
        chk("R8", out_valid, 1'b1);
        chk((m % LINES == 0) ? "R3" : "R1", ch_bit, exp_ch(m));
        if (m % LINES == LINES - 1)
            chk("R2", out_bit, ch_bit);
        chk((m < LAT) ? early_tag : late_tag, out_bit, exp_out(m));
        m++;
    endtask

    // R7: adjacent source bits land STEP*LINES+1 channel positions apart
    task automatic sweep_spacing();
        for (int k = 0; k + 1 < m; k++) begin
            int j = k % LINES;
            if (j < LINES - 1) begin
                int p = k + j * STEP * LINES;
                int q = p + STEP * LINES + 1;
                if (q < m) begin
                    chk("R7", ch_hist[p], in_hist[k]);
                    chk("R7", ch_hist[q], in_hist[k + 1]);
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        do_reset();

        // Directed: sparse ones so misplaced bits are easy to see
        for (int i = 0; i < LAT + 20; i++)
            push((i == 5 || i % 7 == 0) ? 1'b1 : 1'b0, "R6", "R5");
        sweep_spacing();

        // Directed: back-to-back stalls with garbage on in_bit, R4
        for (int i = 0; i < 5; i++) idle();
        for (int i = 0; i < 8; i++) push(1'b1, "R6", "R4");

        // Random stream with random stalls
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 10 < 3)
                idle();
            else
                push(1'($urandom), "R6", "R4");
        end
        sweep_spacing();

        // Mid-run reset, then restart
        do_reset();
        for (int i = 0; i < LAT + 40; i++)
            push(1'($urandom), "R9", "R5");
        sweep_spacing();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule